// File: doc/BRIEF.md
# Quad Low-Side Switch Control Logic

This block is the digital core of a four-channel low-side power switch. It accepts four parallel channel commands, a global enable and a polarity-select input, along with two comparator results per channel from the analog front end. One comparator reports over-temperature. The other reports a drain voltage below the detection threshold, which indicates an open load or a short to ground. From these it produces four registered gate-drive enables and one shared fault flag.

A single select pin sets the active level of the channel commands. The same pin sets the polarity of the fault flag. Faults are qualified by the commanded state of each channel:

- A hot channel counts as a fault only while it is commanded ON, and it is switched off by itself. It restarts as soon as its comparator clears. Because the analog comparator has hysteresis, an overloaded channel pulses on and off.
- A low drain counts as a fault only while the channel is commanded OFF.

A fault reaches the flag only after it has persisted for a programmable number of clock cycles. Every input passes through a two-stage synchronizer. The block has no data stream; all pins are plain level signals with no handshake.

Each channel command, the enable and the select input has a companion "open" input. This input models a pin that is not connected, so the behaviour of an unconnected pin can be checked.

Top module: `quad_lss_ctrl`

## Requirements
- R1: While the effective enable is low, all gate outputs are 0 and the fault flag is 1, whatever the other inputs are. This includes the state directly after reset.
- R2: When the effective select is 1, a channel is commanded ON by a 1 on its command input. When the effective select is 0, a channel is commanded ON by a 0.
- R3: A channel whose open input is 1 reads its command as 0 when the select is 1, and as 1 when the select is 0. The channel is therefore OFF in either polarity.
- R4: When `ena_open_i` is 1, the enable reads as 0. When `prg_open_i` is 1, the select reads as 0.
- R5: A commanded-ON channel whose over-temperature bit is 1 has its gate at 0 and counts as faulted. The other channels are not affected. The gate returns to 1 as soon as the bit clears. An over-temperature bit on a commanded-OFF channel is not a fault.
- R6: A drain-low bit of 1 is a fault only on a channel that is commanded OFF while enabled. On a commanded-ON channel it is ignored.
- R7: While enabled, the flag equals the effective select when no qualified fault is present. It equals the inverse of the select once a fault is indicated.
- R8: The flag switches to the fault level only after the OR of the qualified faults has been 1 for `DLY_CYC` consecutive sampled cycles. Any cycle without a fault restarts the count.
- R9: Both outputs reflect the inputs that were present before the third rising clock edge: two synchronizer stages plus one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ena_i | input | 1 | Global enable, 1 = active |
| ena_open_i | input | 1 | 1 = enable pin unconnected |
| prg_i | input | 1 | Polarity select for commands and flag |
| prg_open_i | input | 1 | 1 = select pin unconnected |
| chan_in_i | input | N_CH | Parallel channel commands |
| chan_open_i | input | N_CH | 1 = channel command pin unconnected |
| ot_i | input | N_CH | Over-temperature comparator, 1 = hot |
| dlow_i | input | N_CH | Drain comparator, 1 = drain below threshold |
| gate_o | output | N_CH | Registered gate-drive enables |
| fault_o | output | 1 | Registered shared fault flag |

## Verification
The bench builds the block with four channels and `DLY_CYC` = 6. This makes fault pulses of exactly five cycles and exactly six cycles, and the restart of the persistence count, cheap to reach, whereas the default of 10000 cycles would take that many cycles per case. A behavioural model predicts both outputs on every clock. The bench drives polarity flips, unconnected pins, thermal cycling of a single channel, and open-load cases under both select levels.

// File: rtl/qls_pkg.sv
package qls_pkg;
  localparam int unsigned QLS_SYNC_STAGES = 2;
  localparam int unsigned QLS_DLY_DEFAULT = 10000; // 100 us at 100 MHz
endpackage

// File: rtl/qls_sync.sv
module qls_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = qls_pkg::QLS_SYNC_STAGES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg[0] <= '0;
    else         stg[0] <= d_i;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[k] <= '0;
      else         stg[k] <= stg[k-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/qls_chan.sv
module qls_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ena_i,
  input  logic prg_i,
  input  logic cmd_i,
  input  logic open_i,
  input  logic ot_i,
  input  logic dlow_i,
  output logic gate_o,
  output logic fault_o
);
  logic cmd_eff, on_cmd, gate_q;

  // unconnected command pin settles at the level that means OFF
  assign cmd_eff = open_i ? ~prg_i : cmd_i;
  assign on_cmd  = ena_i & (prg_i ? cmd_eff : ~cmd_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= on_cmd & ~ot_i;
  end

  assign gate_o  = gate_q;
  assign fault_o = (on_cmd & ot_i) | (ena_i & ~on_cmd & dlow_i);

  p_hot_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_i |=> !gate_q);
  p_polarity_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ena_i && !open_i && !ot_i && (cmd_i == prg_i)) |=> gate_q);
  p_open_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_i |=> !gate_q);
endmodule

// File: rtl/qls_fault_filter.sv
module qls_fault_filter #(
  parameter int unsigned DLY_CYC = qls_pkg::QLS_DLY_DEFAULT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ena_i,
  input  logic prg_i,
  input  logic fault_any_i,
  output logic flag_o
);
  localparam int unsigned CW = $clog2(DLY_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(DLY_CYC);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          flag_q;

  always_comb begin
    if (!fault_any_i)       cnt_nxt = '0;
    else if (cnt_q == CMAX) cnt_nxt = cnt_q;
    else                    cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b1;
    end else begin
      cnt_q <= cnt_nxt;
      if (!ena_i)                flag_q <= 1'b1;
      else if (cnt_nxt == CMAX)  flag_q <= ~prg_i;
      else                       flag_q <= prg_i;
    end
  end

  assign flag_o = flag_q;

  initial begin
    a_dly_min_r8: assert (DLY_CYC >= 2);
  end

  p_quiet_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ena_i && !fault_any_i) |=> (flag_q == $past(prg_i)));
  p_no_early_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ena_i && fault_any_i && cnt_q < CW'(DLY_CYC - 1)) |=> (flag_q == $past(prg_i)));
  p_cnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CMAX);
endmodule

// File: rtl/quad_lss_ctrl.sv
module quad_lss_ctrl #(
  parameter int unsigned N_CH    = 4,
  parameter int unsigned DLY_CYC = qls_pkg::QLS_DLY_DEFAULT
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ena_i,
  input  logic            ena_open_i,
  input  logic            prg_i,
  input  logic            prg_open_i,
  input  logic [N_CH-1:0] chan_in_i,
  input  logic [N_CH-1:0] chan_open_i,
  input  logic [N_CH-1:0] ot_i,
  input  logic [N_CH-1:0] dlow_i,
  output logic [N_CH-1:0] gate_o,
  output logic            fault_o
);
  localparam int unsigned SW = 4 + 4 * N_CH;

  logic [SW-1:0]   raw, syn;
  logic [N_CH-1:0] s_in, s_dlow, s_ot, s_open, ch_fault;
  logic            ena_s, prg_s, fault_any;

  assign raw = {ena_open_i, ena_i, prg_open_i, prg_i,
                chan_open_i, ot_i, dlow_i, chan_in_i};

  qls_sync #(.W(SW)) i_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn)
  );

  assign s_in   = syn[N_CH-1:0];
  assign s_dlow = syn[2*N_CH-1:N_CH];
  assign s_ot   = syn[3*N_CH-1:2*N_CH];
  assign s_open = syn[4*N_CH-1:3*N_CH];
  // unconnected enable or select pin reads as low
  assign prg_s  = syn[4*N_CH]   & ~syn[4*N_CH+1];
  assign ena_s  = syn[4*N_CH+2] & ~syn[4*N_CH+3];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    qls_chan i_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ena_i  (ena_s),
      .prg_i  (prg_s),
      .cmd_i  (s_in[c]),
      .open_i (s_open[c]),
      .ot_i   (s_ot[c]),
      .dlow_i (s_dlow[c]),
      .gate_o (gate_o[c]),
      .fault_o(ch_fault[c])
    );
  end

  assign fault_any = |ch_fault;

  qls_fault_filter #(.DLY_CYC(DLY_CYC)) i_filt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ena_i      (ena_s),
    .prg_i      (prg_s),
    .fault_any_i(fault_any),
    .flag_o     (fault_o)
  );

  p_standby_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ena_s |=> (gate_o == '0 && fault_o));
  p_standby_nofault_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ena_s |-> !fault_any);
endmodule

// File: tb/test_quad_lss_ctrl.sv
module test_quad_lss_ctrl;
  localparam int N = 4;
  localparam int DLY = 6;

  typedef struct packed {
    logic       ena, ena_open, prg, prg_open;
    logic [3:0] cin, opn, ot, dl;
  } vec_t;

  logic clk = 0, rst_n = 0;
  logic ena, ena_open, prg, prg_open;
  logic [N-1:0] cin, opn, ot, dl, gate;
  logic fault;

  quad_lss_ctrl #(.N_CH(N), .DLY_CYC(DLY)) i_quad_lss_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ena_i(ena), .ena_open_i(ena_open),
    .prg_i(prg), .prg_open_i(prg_open), .chan_in_i(cin), .chan_open_i(opn),
    .ot_i(ot), .dlow_i(dl), .gate_o(gate), .fault_o(fault)
  );

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0, m_cnt = 0;
  string cur_req = "R1";
  vec_t hist[$];
  vec_t cur;

  task automatic check_and_apply(input vec_t v);
    vec_t o;
    logic e, p, on, ib, fa, fx;
    logic [3:0] g;
    @(negedge clk);
    o = hist.pop_front();
    e = o.ena && !o.ena_open;
    p = o.prg && !o.prg_open;
    fa = 0; g = '0;
    for (int i = 0; i < N; i++) begin
      ib = o.opn[i] ? !p : o.cin[i];
      on = e && (p ? ib : !ib);
      g[i] = on && !o.ot[i];
      if (on && o.ot[i]) fa = 1;
      if (!on && e && o.dl[i]) fa = 1;
    end
    if (fa) m_cnt = (m_cnt < DLY) ? m_cnt + 1 : DLY;
    else m_cnt = 0;
    fx = !e ? 1'b1 : ((m_cnt == DLY) ? !p : p);
    n_cmp++;
    if (gate !== g) begin
      n_bad++;
      $display("FAIL %s gate act=%b exp=%b at %0t", cur_req, gate, g, $time);
    end
    n_cmp++;
    if (fault !== fx) begin
      n_bad++;
      $display("FAIL %s flag act=%b exp=%b at %0t", cur_req, fault, fx, $time);
    end
    {ena, ena_open, prg, prg_open, cin, opn, ot, dl} = v;
    hist.push_back(v);
  endtask

  task automatic hold(input vec_t v, input int n);
    for (int k = 0; k < n; k++) check_and_apply(v);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog act=running exp=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cur = '0;
    {ena, ena_open, prg, prg_open, cin, opn, ot, dl} = cur;
    for (int k = 0; k < 3; k++) hist.push_back(cur);
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: reset state, then standby with noisy inputs
    cur_req = "R1";
    hold(cur, 3);
    cur = '{ena:0, ena_open:0, prg:1, prg_open:0, cin:4'hF, opn:4'h0, ot:4'h5, dl:4'hA};
    hold(cur, 10);

    // R2/R9: active-high commands
    cur_req = "R2";
    cur = '{ena:1, ena_open:0, prg:1, prg_open:0, cin:4'h5, opn:0, ot:0, dl:0};
    hold(cur, 4);
    cur.cin = 4'hA; hold(cur, 4);
    cur_req = "R9";
    cur.cin = 4'hF; hold(cur, 1); cur.cin = 4'h0; hold(cur, 1); cur.cin = 4'h6; hold(cur, 4);
    cur_req = "R2";
    cur.prg = 0; cur.cin = 4'h5; hold(cur, 4);
    cur.cin = 4'h0; hold(cur, 4);
    cur.cin = 4'hE; hold(cur, 4);

    // R3: unconnected command pins stay OFF in both polarities
    cur_req = "R3";
    cur.prg = 0; cur.cin = 4'h0; cur.opn = 4'h9; hold(cur, 5);
    cur.opn = 4'hF; hold(cur, 4);
    cur.prg = 1; cur.cin = 4'hF; cur.opn = 4'h6; hold(cur, 5);
    cur.opn = 4'h0;

    // R4: unconnected enable / select
    cur_req = "R4";
    cur.ena_open = 1; cur.cin = 4'hF; cur.dl = 4'hF; hold(cur, 10);
    cur.ena_open = 0; cur.dl = 0; cur.prg = 1; cur.prg_open = 1; cur.cin = 4'h3; hold(cur, 5);
    cur.prg_open = 0; hold(cur, 4);

    // R5: thermal shutdown on one ON channel, restart, cycling
    cur_req = "R5";
    cur.prg = 1; cur.cin = 4'hF; cur.ot = 4'h2; hold(cur, 10);
    for (int r = 0; r < 3; r++) begin
      cur.ot = 4'h0; hold(cur, 3);
      cur.ot = 4'h2; hold(cur, 4);
    end
    cur.ot = 4'h0; hold(cur, 4);
    cur.cin = 4'h0; cur.ot = 4'hF; hold(cur, 12);
    cur.ot = 4'h0;

    // R6: open load only in OFF state
    cur_req = "R6";
    cur.cin = 4'h0; cur.dl = 4'h4; hold(cur, 12);
    cur.dl = 4'h0; hold(cur, 4);
    cur.cin = 4'hF; cur.dl = 4'hF; hold(cur, 12);
    cur.dl = 4'h0;

    // R7: flag polarity with select low
    cur_req = "R7";
    cur.prg = 0; cur.cin = 4'hF; cur.dl = 4'h8; hold(cur, 12);
    cur.dl = 4'h0; hold(cur, 5);

    // R8: persistence window edges
    cur_req = "R8";
    cur.prg = 1; cur.cin = 4'h0;
    cur.dl = 4'h1; hold(cur, DLY - 1); cur.dl = 0; hold(cur, 1);
    cur.dl = 4'h1; hold(cur, DLY - 1); cur.dl = 0; hold(cur, 5);
    cur.dl = 4'h1; hold(cur, DLY); cur.dl = 0; hold(cur, 5);
    cur.ena = 0; hold(cur, 5);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule